// File: doc/BRIEF.md
# Receive DMA Ring Buffer Commit Manager

This block sits between an on-chip receive memory and a circular buffer in host memory. Received frames arrive as a stream of 16-bit words. Each frame is announced by a start pulse that carries its byte length. The block turns the words into DMA write offsets inside a ring of 16 or 64 Kbytes. Each frame begins on a 32-bit boundary, so a frame whose length is not a multiple of four leaves a gap of one to three bytes after it. The block records where the latest completed frame begins and how many frames the host has not yet been told about. It also raises a status bit while that count is non-zero.

The host learns of new frames by reading the frame count. That read pins the newest frame in place (commits it). Later frames may not write over the pinned frame. The pin is lifted in any of three ways: the host reads the count again, the host reads the buffer-event status while newer frames are waiting (an implied skip), or the host writes the reset command. A frame that would run into pinned space is refused as a whole. The refusal is flagged for one cycle. A refused frame is never written in part. A fourth register returns a receive-event word from elsewhere in the receiver, and it reads as zero while DMA mode is selected.

Top module: `rx_ring_dma`

## Requirements
- R1: The frame accepted with length L writes ceil(L/2) words. `dma_we` is high in each cycle that `wd_valid` is high during the frame. `dma_addr` starts at the frame start and steps by 2 bytes per word. It wraps modulo the ring size: 16384 bytes when `ring_64k`=0 and 65536 bytes when `ring_64k`=1. `dma_wdata` equals `wd_data` in the same cycle.
- R2: The first frame after reset starts at offset 0. Each later frame starts at the previous accepted start plus L rounded up to a multiple of 4, modulo the ring size.
- R3: A host read with `hst_sel`=1 returns the start offset of the most recently completed accepted frame.
- R4: The frame count (`hst_sel`=0) rises by one at the last word of each accepted frame. A read returns the count, and the count becomes 0 after that read.
- R5: A read with `hst_sel`=2 returns bit 7 set exactly when the frame count is non-zero, with every other bit 0. Such a read does not clear bit 7.
- R6: A count read that sees a non-zero count commits the most recently completed frame. While a frame is committed, a new frame is dropped when its rounded length exceeds (commit start − write pointer) mod ring size. A dropped frame raises `ovf_evt` in its `frm_start` cycle, performs no writes, is not counted, and leaves the write pointer where it was.
- R7: A count read made while a frame is committed releases that frame. If the count is non-zero at that read, the newest frame becomes committed in its place.
- R8: A read with `hst_sel`=2 made while a frame is committed and the count is non-zero releases the commitment.
- R9: A host write with `hst_sel`=2 and `hst_wdata[0]`=1 does the following: it clears the count and the commitment, sets the start-of-frame register and the write pointer to 0, and abandons any frame in progress.
- R10: A read with `hst_sel`=3 returns 0 when `dma_mode`=1, and returns `rx_evt_in` otherwise.
- R11: After `rst_n` is released, the reads with select 0, 1 and 2 return 0, and no DMA write occurs without a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_64k | input | 1 | Ring size: 0 = 16 KB, 1 = 64 KB |
| dma_mode | input | 1 | Receive DMA mode enabled |
| frm_start | input | 1 | Start of a frame, one cycle |
| frm_len | input | 16 | Frame length in bytes, valid with frm_start |
| wd_valid | input | 1 | Frame word valid |
| wd_data | input | 16 | Frame word |
| rx_evt_in | input | 16 | Receive-event word from the receiver |
| hst_rd | input | 1 | Host register read strobe |
| hst_wr | input | 1 | Host register write strobe |
| hst_sel | input | 2 | Host register select |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, same cycle as hst_rd |
| dma_we | output | 1 | DMA word write enable |
| dma_addr | output | 16 | DMA byte offset into the ring |
| dma_wdata | output | 16 | DMA write data |
| ovf_evt | output | 1 | Frame dropped for lack of free space |

## Verification
The DMA write outputs and `ovf_evt` are combinational. They are due in the same cycle as the `wd_valid` or `frm_start` that causes them. `hst_rdata` is likewise due in the cycle of `hst_rd`. The effects of a read or command on state (count cleared, commitment taken or released, pointer reset) appear from the next cycle on. The bench drives inputs just after a rising edge and compares outputs at the following falling edge. A scoreboard queue holds the expected offset and data of every word. The monitor pops the queue on each write, so a write from a dropped frame, or a missing write, is caught in the cycle it happens.

// File: rtl/rx_ring_dma.sv
`timescale 1ns/1ps
module rx_ring_dma #(
  parameter int AW = 16,
  parameter int SW = 14,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ring_64k,
  input  logic          dma_mode,
  input  logic          frm_start,
  input  logic [AW-1:0] frm_len,
  input  logic          wd_valid,
  input  logic [15:0]   wd_data,
  input  logic [15:0]   rx_evt_in,
  input  logic          hst_rd,
  input  logic          hst_wr,
  input  logic [1:0]    hst_sel,
  input  logic [15:0]   hst_wdata,
  output logic [15:0]   hst_rdata,
  output logic          dma_we,
  output logic [AW-1:0] dma_addr,
  output logic [15:0]   dma_wdata,
  output logic          ovf_evt
);
  localparam logic [AW-1:0] SMALL_MASK = AW'((1 << SW) - 1);

  logic [AW-1:0] mask, wp, cur, fstart, wnext, sof, cstart, wleft;
  logic [CW-1:0] cnt, cnt_base;
  logic          act, drop, committed;
  logic [AW:0]   need, free, wl_init;
  logic          fcnt_rd, bev_rd, rst_cmd, accept, last, done;

  assign mask    = ring_64k ? '1 : SMALL_MASK;
  assign need    = ({1'b0, frm_len} + (AW+1)'(3)) & ~(AW+1)'(3);
  assign wl_init = ({1'b0, frm_len} + (AW+1)'(1)) >> 1;
  assign free    = committed ? {1'b0, (cstart - wp) & mask} : {1'b0, mask} + (AW+1)'(1);

  assign fcnt_rd = hst_rd && hst_sel == 2'd0;
  assign bev_rd  = hst_rd && hst_sel == 2'd2;
  assign rst_cmd = hst_wr && hst_sel == 2'd2 && hst_wdata[0];

  assign accept  = frm_start && !act && frm_len != '0 && !rst_cmd;
  assign ovf_evt = accept && need > free;
  assign last    = act && wd_valid && wleft == AW'(1);
  assign done    = last && !drop && !rst_cmd;

  assign dma_we    = act && !drop && wd_valid;
  assign dma_addr  = cur;
  assign dma_wdata = wd_data;

  assign cnt_base = fcnt_rd ? '0 : cnt;

  always_comb begin
    case (hst_sel)
      2'd0:    hst_rdata = 16'(cnt);
      2'd1:    hst_rdata = 16'(sof);
      2'd2:    hst_rdata = {8'h00, cnt != '0, 7'h00};
      default: hst_rdata = dma_mode ? 16'h0000 : rx_evt_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rst_cmd) begin
      wp <= '0; cur <= '0; fstart <= '0; wnext <= '0; sof <= '0; cstart <= '0;
      wleft <= '0; cnt <= '0; act <= 1'b0; drop <= 1'b0; committed <= 1'b0;
    end else begin
      if (accept) begin
        act    <= 1'b1;
        drop   <= ovf_evt;
        cur    <= wp;
        fstart <= wp;
        wleft  <= wl_init[AW-1:0];
        wnext  <= (wp + need[AW-1:0]) & mask;
      end else if (act && wd_valid) begin
        cur   <= (cur + AW'(2)) & mask;
        wleft <= wleft - AW'(1);
        if (last) begin
          act <= 1'b0;
          if (!drop) begin
            wp  <= wnext;
            sof <= fstart;
          end
        end
      end

      if (done && cnt_base != '1) cnt <= cnt_base + CW'(1);
      else                        cnt <= cnt_base;

      if (fcnt_rd) begin
        committed <= cnt != '0;
        cstart    <= sof;
      end else if (bev_rd && committed && cnt != '0) begin
        committed <= 1'b0;
      end
    end
  end

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_we && $past(dma_we) && !$past(last) && !$past(rst_cmd) && $stable(ring_64k))
      |-> dma_addr == (($past(dma_addr) + AW'(2)) & mask));

  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt_rd && !done) |=> cnt == '0);

  // R5
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bev_rd && cnt != '0 && !rst_cmd) |=> hst_sel != 2'd2 || hst_rdata[7]);

  // R8
  implied_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bev_rd && committed && cnt != '0) |=> !committed);

  // R9
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> (wp == '0 && cnt == '0 && !committed && !act));

  // R10
  rxevt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && hst_sel == 2'd3) |-> hst_rdata == 16'h0000);
endmodule

// File: tb/rx_ring_dma_tb.sv
`timescale 1ns/1ps
module rx_ring_dma_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ring_64k = 1'b0, dma_mode = 1'b1, frm_start = 1'b0, wd_valid = 1'b0;
  logic [15:0] frm_len = '0, wd_data = '0, rx_evt_in = '0, hst_wdata = '0;
  logic hst_rd = 1'b0, hst_wr = 1'b0;
  logic [1:0] hst_sel = '0;
  logic [15:0] hst_rdata, dma_addr, dma_wdata;
  logic dma_we, ovf_evt;

  int n_chk = 0, n_fail = 0;
  logic [31:0] sbq[$];

  always #2 clk = ~clk;

  rx_ring_dma u_dut (
    .clk(clk), .rst_n(rst_n), .ring_64k(ring_64k), .dma_mode(dma_mode),
    .frm_start(frm_start), .frm_len(frm_len), .wd_valid(wd_valid), .wd_data(wd_data),
    .rx_evt_in(rx_evt_in), .hst_rd(hst_rd), .hst_wr(hst_wr), .hst_sel(hst_sel),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .dma_we(dma_we), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .ovf_evt(ovf_evt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && dma_we) begin
      if (sbq.size() == 0) check("R1/R6 unexpected write", {dma_addr, dma_wdata}, 32'hxxxxxxxx);
      else check("R1 write", {dma_addr, dma_wdata}, sbq.pop_front());
    end
  end

  task automatic hread(input logic [1:0] sel, input logic [15:0] exp, input string req);
    @(posedge clk); #1;
    hst_rd = 1'b1; hst_sel = sel;
    @(negedge clk);
    check(req, {16'h0, hst_rdata}, {16'h0, exp});
    @(posedge clk); #1;
    hst_rd = 1'b0;
  endtask

  task automatic send_frame(input int len, input int start, input bit ok, input int ring);
    int nw = (len + 1) / 2;
    @(posedge clk); #1;
    frm_start = 1'b1; frm_len = 16'(len);
    @(negedge clk);
    check("R6 ovf_evt", {31'h0, ovf_evt}, {31'h0, !ok});
    if (ok) for (int i = 0; i < nw; i++)
      sbq.push_back({16'((start + 2*i) % ring), 16'(len ^ (i * 7))});
    @(posedge clk); #1;
    frm_start = 1'b0;
    for (int i = 0; i < nw; i++) begin
      wd_valid = 1'b1; wd_data = 16'(len ^ (i * 7));
      @(posedge clk); #1;
    end
    wd_valid = 1'b0;
    @(negedge clk);
    check("R1/R2 all words seen", sbq.size(), 0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    hread(2'd0, 16'h0, "R11 count");
    hread(2'd1, 16'h0, "R11 sof");
    hread(2'd2, 16'h0, "R11 bufevt");
    rx_evt_in = 16'h1234;
    hread(2'd3, 16'h0, "R10 dma mode");
    dma_mode = 1'b0;
    hread(2'd3, 16'h1234, "R10 no dma");
    dma_mode = 1'b1;

    send_frame(5, 0, 1, 16384);
    hread(2'd2, 16'h0080, "R5 flag set");
    hread(2'd2, 16'h0080, "R5 flag kept");
    hread(2'd1, 16'd0, "R3 sof");
    send_frame(6, 8, 1, 16384);
    hread(2'd1, 16'd8, "R3 sof second");
    hread(2'd0, 16'd2, "R4 count");
    send_frame(16376, 16, 1, 16384);
    send_frame(1, 8, 0, 16384);
    hread(2'd0 + 2'd2, 16'h0080, "R8 skip read");
    send_frame(2, 8, 1, 16384);
    hread(2'd1, 16'd8, "R3 after wrap");
    hread(2'd0, 16'd2, "R6 commit read");
    hread(2'd0, 16'd0, "R7 reread");
    send_frame(16384, 12, 1, 16384);
    hread(2'd0, 16'd1, "R4 count after release");

    @(posedge clk); #1;
    hst_wr = 1'b1; hst_sel = 2'd2; hst_wdata = 16'h0001;
    @(posedge clk); #1;
    hst_wr = 1'b0; hst_wdata = 16'h0;
    hread(2'd0, 16'd0, "R9 count cleared");
    hread(2'd1, 16'd0, "R9 sof cleared");
    ring_64k = 1'b1;
    send_frame(16392, 0, 1, 65536);
    hread(2'd1, 16'd0, "R9 start at zero");
    hread(2'd0, 16'd1, "R4 final count");
    hread(2'd2, 16'h0000, "R5 flag clear");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule